// File: doc/BRIEF.md
# Performance Monitor Counter Unit

The unit counts processor activity in six 32-bit counters that are set up through a small control register and an event-select register. Counters one to four each take an 8-bit event code from their own byte of the select register. The code picks completed instructions, processor cycles or nothing at all. Counter five always counts completed instructions and counter six always counts cycles. A freeze bit in the control register stops all six counters at once.

Counter one can raise a sign-crossing alert. When that alert is armed and counting carries counter one from 0x7FFFFFFF to 0x80000000, the unit acts on the alert in the same clock edge. It can freeze all counters, it turns an alert-enable bit into an alert-seen bit, and it drives a one-cycle interrupt pulse. Software reads and writes every register through a single address port. The read data is the register the address selects, with no delay.

Top module: `pmu_unit`

## Requirements
- R1: While and after reset, every register reads zero and `pm_irq` is low.
- R2: Address map: 0 control, 1 event select, 2 to 7 counters one to six. A write with `reg_we` high changes the addressed register on the next rising edge. `reg_rdata` always shows the register at `reg_addr`.
- R3: Counter k (k = 1..4) takes its event code from select bits [8k-1:8k-8]. Code 0x02 adds one per cycle with `inst_done` high. Code 0x1E adds one per cycle with `cyc_tick` high. Any other code leaves the counter unchanged.
- R4: Counter five adds one on every `inst_done` and counter six adds one on every `cyc_tick`, whatever the select register holds.
- R5: While control bit 0 (freeze) is set, no counter changes except by a software write.
- R6: A software write to a counter takes priority over an increment of that counter in the same cycle.
- R7: `pm_irq` pulses high for one cycle after the edge on which counting takes counter one from 0x7FFFFFFF to 0x80000000. This happens only while control bit 5 (sign alert armed) and bit 4 (alert delivery enabled) are both set, counters are not frozen, and the same cycle writes neither the control register nor counter one.
- R8: If bit 5 or bit 4 of the control register is clear, the crossing raises no pulse and leaves the control register unchanged.
- R9: On an acted-on alert with control bit 1 (freeze-on-alert) set, bit 1 clears and bit 0 sets in the same edge.
- R10: On an acted-on alert with control bit 2 (alert enable) set, bit 2 clears and bit 3 (alert seen) sets in the same edge.
- R11: Counters wrap from 0xFFFFFFFF to 0 without raising an alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| inst_done | input | 1 | One instruction completed this cycle |
| cyc_tick | input | 1 | One processor cycle elapsed |
| pm_irq | output | 1 | Single-cycle alert interrupt pulse |

## Verification
The bench builds the unit with its default values: 32-bit counters, four programmable counters and 8-bit codes. It does not take 2^31 cycles to reach the sign crossing. Instead it preloads counter one a few counts below 0x80000000 and counters near 0xFFFFFFFF, so the alert and the wrap both come within a few cycles. Random select bytes are drawn from the two live codes and from dead codes. Together with random freeze and enable bits, this mix exercises every branch of the alert and the priority of writes.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int REG_W    = 32;
    localparam int SEL_W    = 8;
    localparam int NUM_CNT  = 6;
    localparam int NUM_PROG = 4;
    localparam int ADDR_W   = 3;

    localparam logic [SEL_W-1:0] EV_INST = 8'h02;
    localparam logic [SEL_W-1:0] EV_CYC  = 8'h1E;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT0 = 3'd2;

    typedef struct packed {
        logic [REG_W-7:0] spare;
        logic             sign_arm;
        logic             deliver_en;
        logic             alert_seen;
        logic             alert_en;
        logic             frz_on_alert;
        logic             frz;
    } ctrl_t;

    // Fixed code for the counters that follow the programmable ones.
    function automatic logic [SEL_W-1:0] fixed_code(input int idx);
        return (idx == NUM_PROG) ? EV_INST : EV_CYC;
    endfunction
endpackage

// File: rtl/pmu_event_decode.sv
module pmu_event_decode
    import pmu_pkg::*;
(
    input  logic [SEL_W-1:0] code,
    input  logic             inst_done,
    input  logic             cyc_tick,
    output logic             hit
);
    always_comb begin
        unique case (code)
            EV_INST: hit = inst_done;
            EV_CYC:  hit = cyc_tick;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr)
            q <= wdata;
        else if (inc)
            q <= q + W'(1);
    end
endmodule

// File: rtl/pmu_alert.sv
module pmu_alert
    import pmu_pkg::*;
(
    input  ctrl_t            ctrl_q,
    input  logic             cnt0_at_edge,
    input  logic             cnt0_inc,
    input  logic             cnt0_wr,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_d,
    output logic             alert
);
    always_comb begin
        alert = ctrl_q.sign_arm && ctrl_q.deliver_en && !ctrl_q.frz
                && cnt0_inc && cnt0_at_edge && !cnt0_wr && !ctrl_wr;
        ctrl_d = ctrl_q;
        if (alert) begin
            if (ctrl_q.frz_on_alert) begin
                ctrl_d.frz_on_alert = 1'b0;
                ctrl_d.frz          = 1'b1;
            end
            if (ctrl_q.alert_en) begin
                ctrl_d.alert_en   = 1'b0;
                ctrl_d.alert_seen = 1'b1;
            end
        end
        if (ctrl_wr)
            ctrl_d = ctrl_t'(wdata);
    end
endmodule

// File: rtl/pmu_unit.sv
module pmu_unit
    import pmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              inst_done,
    input  logic              cyc_tick,
    output logic              pm_irq
);
    localparam logic [REG_W-1:0] EDGE_VAL = {1'b0, {(REG_W-1){1'b1}}};

    ctrl_t              ctrl_q, ctrl_d;
    logic [REG_W-1:0]   sel_q;
    logic [REG_W-1:0]   pmc_q [NUM_CNT];
    logic [NUM_CNT-1:0] hit, cnt_wr;
    logic               alert;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic [SEL_W-1:0] code;
        if (i < NUM_PROG) begin : g_prog
            assign code = sel_q[i*SEL_W +: SEL_W];
        end else begin : g_fixed
            assign code = fixed_code(i);
        end

        pmu_event_decode u_dec (
            .code      (code),
            .inst_done (inst_done),
            .cyc_tick  (cyc_tick),
            .hit       (hit[i])
        );

        assign cnt_wr[i] = reg_we && (reg_addr == A_CNT0 + ADDR_W'(i));

        pmu_counter #(.W(REG_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .wr    (cnt_wr[i]),
            .wdata (reg_wdata),
            .inc   (hit[i] && !ctrl_q.frz),
            .q     (pmc_q[i])
        );
    end

    pmu_alert u_alert (
        .ctrl_q       (ctrl_q),
        .cnt0_at_edge (pmc_q[0] == EDGE_VAL),
        .cnt0_inc     (hit[0] && !ctrl_q.frz),
        .cnt0_wr      (cnt_wr[0]),
        .ctrl_wr      (reg_we && reg_addr == A_CTRL),
        .wdata        (reg_wdata),
        .ctrl_d       (ctrl_d),
        .alert        (alert)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            sel_q  <= '0;
            pm_irq <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            pm_irq <= alert;
            if (reg_we && reg_addr == A_SEL)
                sel_q <= reg_wdata;
        end
    end

    always_comb begin
        if (reg_addr == A_CTRL)
            reg_rdata = ctrl_q;
        else if (reg_addr == A_SEL)
            reg_rdata = sel_q;
        else
            reg_rdata = pmc_q[reg_addr - A_CNT0];
    end
endmodule

// File: rtl/pmu_unit_chk.sv
module pmu_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [31:0] ctrl,
    input logic [31:0] cnt0,
    input logic [31:0] cnt4,
    input logic        pm_irq
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pm_irq |=> !pm_irq); // R7
    AST_IRQ_SIGN_SET: assert property (@(posedge clk) disable iff (rst)
        pm_irq |-> cnt0[31] && !$past(cnt0[31])); // R7
    AST_IRQ_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (rst)
        pm_irq |-> $past(ctrl[5]) && $past(ctrl[4])); // R8
    AST_FREEZE_ON_ALERT: assert property (@(posedge clk) disable iff (rst)
        pm_irq && $past(ctrl[1]) |-> ctrl[0] && !ctrl[1]); // R9
    AST_ALERT_SEEN: assert property (@(posedge clk) disable iff (rst)
        pm_irq && $past(ctrl[2]) |-> ctrl[3] && !ctrl[2]); // R10
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        ctrl[0] && !(reg_we && reg_addr == 3'd6) |=> $stable(cnt4)); // R5
endmodule

bind pmu_unit pmu_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .ctrl     (ctrl_q),
    .cnt0     (pmc_q[0]),
    .cnt4     (pmc_q[4]),
    .pm_irq   (pm_irq)
);

// File: tb/pmu_unit_tb.sv
`timescale 1ns/1ps
module pmu_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        inst_done = 1'b0;
    logic        cyc_tick = 1'b0;
    logic        pm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_ctrl, m_sel;
    logic [31:0] m_cnt [6];
    logic        m_irq;

    always #2.5 clk = ~clk;

    pmu_unit u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .inst_done(inst_done), .cyc_tick(cyc_tick), .pm_irq(pm_irq)
    );

    function automatic logic ev_hit(logic [7:0] c, logic ins, logic cy);
        if (c == 8'h02) return ins;
        if (c == 8'h1E) return cy;
        return 1'b0;
    endfunction

    function automatic logic [31:0] m_reg(logic [2:0] a);
        if (a == 3'd0) return m_ctrl;
        if (a == 3'd1) return m_sel;
        return m_cnt[a - 3'd2];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic model_step(logic we, logic [2:0] a, logic [31:0] wd,
                              logic ins, logic cy);
        logic [31:0] nxt [6];
        logic hits [6];
        logic alert;
        for (int k = 0; k < 6; k++) begin
            if (k < 4) hits[k] = ev_hit(m_sel[8*k +: 8], ins, cy);
            else hits[k] = (k == 4) ? ins : cy;
            nxt[k] = (hits[k] && !m_ctrl[0]) ? m_cnt[k] + 32'd1 : m_cnt[k];
            if (we && a == 3'(k + 2)) nxt[k] = wd;
        end
        alert = m_ctrl[5] && m_ctrl[4] && !m_ctrl[0] && hits[0]
                && m_cnt[0] == 32'h7FFF_FFFF && !(we && (a == 3'd0 || a == 3'd2));
        if (alert) begin
            if (m_ctrl[1]) begin m_ctrl[1] = 1'b0; m_ctrl[0] = 1'b1; end
            if (m_ctrl[2]) begin m_ctrl[2] = 1'b0; m_ctrl[3] = 1'b1; end
        end
        if (we && a == 3'd0) m_ctrl = wd;
        if (we && a == 3'd1) m_sel = wd;
        for (int k = 0; k < 6; k++) m_cnt[k] = nxt[k];
        m_irq = alert;
    endtask

    task automatic step(string tag, logic we, logic [2:0] a, logic [31:0] wd,
                        logic ins, logic cy);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd;
        inst_done = ins; cyc_tick = cy;
        model_step(we, a, wd, ins, cy);
        @(posedge clk);
        #1;
        check({tag, " irq"}, {31'd0, pm_irq}, {31'd0, m_irq});
        check({tag, " read"}, reg_rdata, m_reg(a));
    endtask

    task automatic wr(string tag, logic [2:0] a, logic [31:0] wd);
        step(tag, 1'b1, a, wd, 1'b0, 1'b0);
    endtask

    task automatic rd(string tag, logic [2:0] a, logic ins, logic cy);
        step(tag, 1'b0, a, '0, ins, cy);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20211));
        m_ctrl = '0; m_sel = '0; m_irq = 1'b0;
        for (int k = 0; k < 6; k++) m_cnt[k] = '0;
        repeat (3) @(posedge clk);
        // R1: reset values
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            reg_addr = 3'(a);
            #1;
            check("R1 reset read", reg_rdata, 32'd0);
        end
        check("R1 reset irq", {31'd0, pm_irq}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // R2: select write, counter one=0x02, two=0x1E, three dead, four=0x02
        wr("R2", 3'd1, 32'h02_55_1E_02);
        rd("R2", 3'd1, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++)
            rd("R3", 3'(2 + i % 4), 1'(i % 2), 1'(i % 3 == 0));
        for (int i = 0; i < 6; i++)
            rd("R4", 3'(6 + i % 2), 1'(i % 3 == 0), 1'b1);

        // R5: frozen counters hold
        wr("R5", 3'd0, 32'h1);
        for (int i = 0; i < 6; i++) rd("R5", 3'(2 + i), 1'b1, 1'b1);
        wr("R5", 3'd0, 32'h0);

        // R6: write wins over increment
        step("R6", 1'b1, 3'd3, 32'h1234_5678, 1'b1, 1'b1);
        step("R6", 1'b1, 3'd7, 32'h0000_0100, 1'b1, 1'b1);
        rd("R6", 3'd7, 1'b0, 1'b0);

        // R11: wrap without alert
        wr("R11", 3'd0, 32'h36);
        wr("R11", 3'd5, 32'hFFFF_FFFF);
        rd("R11", 3'd5, 1'b1, 1'b0);
        rd("R11", 3'd5, 1'b1, 1'b0);

        // R7, R9, R10: alert with freeze-on-alert and alert enable
        wr("R7", 3'd2, 32'h7FFF_FFFD);
        rd("R7", 3'd2, 1'b1, 1'b0);
        rd("R7", 3'd2, 1'b1, 1'b0);
        rd("R7", 3'd2, 1'b1, 1'b0);
        rd("R9", 3'd0, 1'b1, 1'b1);
        rd("R10", 3'd0, 1'b1, 1'b1);
        rd("R9", 3'd6, 1'b1, 1'b1);

        // R10 only: alert enable without freeze-on-alert
        wr("R10", 3'd0, 32'h34);
        wr("R10", 3'd2, 32'h7FFF_FFFF);
        rd("R10", 3'd0, 1'b1, 1'b0);
        rd("R10", 3'd0, 1'b0, 1'b0);

        // R8: crossing with delivery disabled, then with arm disabled
        wr("R8", 3'd0, 32'h26);
        wr("R8", 3'd2, 32'h7FFF_FFFF);
        rd("R8", 3'd0, 1'b1, 1'b0);
        wr("R8", 3'd0, 32'h16);
        wr("R8", 3'd2, 32'h7FFF_FFFF);
        rd("R8", 3'd0, 1'b1, 1'b0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [2:0] a;
            logic [31:0] d;
            r = int'($urandom_range(0, 99));
            a = 3'($urandom_range(0, 7));
            if (r < 12) begin
                case (a)
                    3'd0: d = {26'd0, 6'($urandom) & 6'h3E | 6'($urandom_range(0, 3) == 0)};
                    3'd1: begin
                        d = '0;
                        for (int b = 0; b < 4; b++)
                            d[8*b +: 8] = ($urandom_range(0, 2) == 0) ? 8'h1E :
                                          ($urandom_range(0, 1) == 0) ? 8'h02 : 8'($urandom);
                    end
                    default: d = ($urandom_range(0, 1) == 0) ?
                                 32'h7FFF_FFF8 + 32'($urandom_range(0, 7)) :
                                 32'hFFFF_FFF8 + 32'($urandom_range(0, 7));
                endcase
                step("R2 random", 1'b1, a, d, 1'($urandom), 1'($urandom));
            end else begin
                step("R3 random", 1'b0, a, '0, 1'($urandom), 1'($urandom));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule